// File: doc/BRIEF.md
# Peripheral I/O Register Space

This block holds the register space that a small 8-bit core sees for its peripherals. One access arrives per cycle, marked by `req_en`. A three-bit kind selects how the address is read. A port access takes a short 6-bit I/O number. A data access takes a load/store address in which the same registers sit 0x20 higher. Three more kinds set, clear or test one bit. These work only on the low 32 I/O numbers.

Eight registers are implemented:

| Name | I/O number | Data address | Contents |
|------|------------|--------------|----------|
| GP0 | 0x02 | 0x022 | General-purpose byte |
| FLAGA | 0x05 | 0x025 | Eight flags; writing a one clears a flag |
| CTRLA | 0x0C | 0x02C | Six plain control bits |
| FLAGB | 0x1A | 0x03A | Four plain control bits (7:4) and four flags (3:0) |
| GP1 | 0x2A | 0x04A | General-purpose byte |
| GP2 | 0x3E | 0x05E | General-purpose byte |
| EXTA | none | 0x0A0 | Byte in the extended window |
| EXTB | none | 0x1FF | Four bits in the extended window |

Hardware can raise each flag through a dedicated set input. Any address that is not implemented reads as zero. A write to such an address is dropped and reported on the error output.

Reads are combinational, so `rd_data` and `bit_val` reflect the access in the same cycle. Writes land on the rising edge. The block never stalls: there is no valid/ready handshake, every request is taken in its own cycle, and nothing can apply back-pressure.

Top module: `iospace_regfile`

## Requirements
- R1: With kind 0 (port), I/O numbers 0x00 to 0x3F reach the registers. A port access with an address of 0x40 or above raises `err` in the next cycle, reads 0 and changes nothing.
- R2: With kind 1 (data), the register at I/O number n is reached at address n+0x20. A data address below 0x20 or above 0x1FF raises `err` in the next cycle, reads 0 and changes nothing.
- R3: EXTA (data address 0x0A0, 8 bits) and EXTB (data address 0x1FF, bits 3:0) can be reached only with kind 1. No port number maps to them.
- R4: Kinds 2 (bit set), 3 (bit clear) and 4 (bit test) are legal only for I/O numbers below 0x20. Outside that range they raise `err` in the next cycle, leave every register unchanged and give `bit_val` 0.
- R5: A bit set or bit clear changes only the bit chosen by `bit_sel`. Flags elsewhere in the same register keep their value.
- R6: Flag bits are FLAGA bits 7:0 and FLAGB bits 3:0. Writing a one clears a flag, and writing a zero leaves it unchanged. A bit set on a flag bit clears that flag. A bit clear on a flag bit has no effect.
- R7: A flag whose hardware set input (`flag_a_set`, `flag_b_set`) is high is 1 after that edge, even if the same cycle clears it.
- R8: GP0 (I/O 0x02), GP1 (I/O 0x2A) and GP2 (I/O 0x3E) store any byte written.
- R9: Reserved bits read as 0. These are CTRLA bits 7:6 and EXTB bits 7:4.
- R10: A write, bit set or bit clear to an unimplemented address inside a legal range is dropped and raises `err` for one cycle. A read of such an address returns 0 with no error.
- R11: `rd_data` shows the addressed register in the same cycle for kinds 0 and 1. `bit_val` shows the chosen bit in the same cycle for kind 4. A synchronous reset clears every register and `err`.
- R12: Kinds 5 to 7 are illegal. They raise `err` in the next cycle and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_en | input | 1 | Access strobe for this cycle |
| req_kind | input | 3 | 0 port, 1 data, 2 bit set, 3 bit clear, 4 bit test |
| req_wr | input | 1 | Write (1) or read (0) for kinds 0 and 1 |
| req_addr | input | 10 | I/O number or data address |
| wr_data | input | 8 | Byte to write |
| bit_sel | input | 3 | Bit index for the bit operations |
| flag_a_set | input | 8 | Hardware set of the FLAGA flags |
| flag_b_set | input | 4 | Hardware set of the FLAGB flags |
| rd_data | output | 8 | Read data, combinational |
| bit_val | output | 1 | Bit-test result, combinational |
| err | output | 1 | One-cycle error pulse after an illegal or dropped access |

## Verification
The assertions watch every cycle for the following:
- out-of-range port, data and bit accesses, and illegal kinds, are followed by `err`;
- an illegal bit test never returns a one;
- `err` stays quiet after an idle cycle;
- reserved bits remain zero;
- a hardware flag set wins over a software clear.

Only the bench's scenarios can show the rest:
- the address map, through port, data and bit sweeps against an arithmetic model;
- that a bit operation leaves neighbouring flags intact while a full-byte write clears them;
- that dropped accesses leave the stored values unchanged.

// File: rtl/iosp_pkg.sv
package iosp_pkg;
  localparam int DW = 8;
  localparam int AW = 10;
  localparam int BW = 3;
  localparam int NREG = 8;
  localparam logic [AW-1:0] IO_OFS = 10'h020;
  localparam logic [AW-1:0] PORT_TOP = 10'h040;
  localparam logic [AW-1:0] BIT_TOP = 10'h020;
  localparam logic [AW-1:0] DATA_LO = 10'h020;
  localparam logic [AW-1:0] DATA_HI = 10'h1FF;
  localparam int IDX_FLAGA = 1;
  localparam int IDX_CTRLA = 2;
  localparam int IDX_FLAGB = 3;
  localparam int IDX_EXTB = 7;

  typedef enum logic [2:0] {
    ACC_PORT  = 3'd0,
    ACC_DATA  = 3'd1,
    ACC_BSET  = 3'd2,
    ACC_BCLR  = 3'd3,
    ACC_BTEST = 3'd4
  } acc_e;

  // data-space address of each implemented register
  function automatic logic [AW-1:0] reg_daddr(input int i);
    case (i)
      0: return 10'h022;
      1: return 10'h025;
      2: return 10'h02C;
      3: return 10'h03A;
      4: return 10'h04A;
      5: return 10'h05E;
      6: return 10'h0A0;
      default: return 10'h1FF;
    endcase
  endfunction

  // bits that exist in each register
  function automatic logic [DW-1:0] reg_mask(input int i);
    case (i)
      IDX_CTRLA: return 8'h3F;
      IDX_EXTB:  return 8'h0F;
      default:   return 8'hFF;
    endcase
  endfunction

  // bits that are write-one-to-clear flags
  function automatic logic [DW-1:0] reg_w1c(input int i);
    case (i)
      IDX_FLAGA: return 8'hFF;
      IDX_FLAGB: return 8'h0F;
      default:   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/iosp_decode.sv
module iosp_decode
  import iosp_pkg::*;
(
  input  logic          req_en,
  input  logic [2:0]    req_kind,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [BW-1:0] bit_sel,
  output logic [NREG-1:0] hit,
  output logic          do_write,
  output logic          do_test,
  output logic          do_read,
  output logic [DW-1:0] wmask,
  output logic [DW-1:0] wval,
  output logic          bad
);
  logic          legal;
  logic          wr_kind;
  logic [AW-1:0] daddr;
  logic [DW-1:0] bmask;

  always_comb begin
    legal   = 1'b0;
    wr_kind = 1'b0;
    daddr   = '0;
    wmask   = '0;
    wval    = '0;
    do_test = 1'b0;
    do_read = 1'b0;
    bmask   = 8'h01 << bit_sel;
    case (req_kind)
      ACC_PORT: begin
        legal   = req_addr < PORT_TOP;
        daddr   = req_addr + IO_OFS;
        wr_kind = req_wr;
        do_read = 1'b1;
        wmask   = '1;
        wval    = wr_data;
      end
      ACC_DATA: begin
        legal   = (req_addr >= DATA_LO) && (req_addr <= DATA_HI);
        daddr   = req_addr;
        wr_kind = req_wr;
        do_read = 1'b1;
        wmask   = '1;
        wval    = wr_data;
      end
      ACC_BSET: begin
        legal   = req_addr < BIT_TOP;
        daddr   = req_addr + IO_OFS;
        wr_kind = 1'b1;
        wmask   = bmask;
        wval    = '1;
      end
      ACC_BCLR: begin
        legal   = req_addr < BIT_TOP;
        daddr   = req_addr + IO_OFS;
        wr_kind = 1'b1;
        wmask   = bmask;
        wval    = '0;
      end
      ACC_BTEST: begin
        legal   = req_addr < BIT_TOP;
        daddr   = req_addr + IO_OFS;
        do_test = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = req_en && legal && (daddr == reg_daddr(i));
  end

  assign do_write = req_en && legal && wr_kind;
  assign bad = req_en && (!legal || (wr_kind && (hit == '0)));
endmodule

// File: rtl/iosp_cell.sv
module iosp_cell
  import iosp_pkg::*;
#(
  parameter logic [DW-1:0] MASK = 8'hFF,
  parameter logic [DW-1:0] W1C  = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wmask,
  input  logic [DW-1:0] wval,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] PLAIN = MASK & ~W1C;
  localparam logic [DW-1:0] FLAGS = MASK & W1C;

  logic [DW-1:0] wm;
  logic [DW-1:0] nxt;

  always_comb begin
    wm  = we ? wmask : '0;
    nxt = (((q & ~wm) | (wval & wm)) & PLAIN)
        | (((q & ~(wm & wval)) | hw_set) & FLAGS);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/iospace_regfile.sv
module iospace_regfile
  import iosp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_en,
  input  logic [2:0] req_kind,
  input  logic       req_wr,
  input  logic [9:0] req_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] bit_sel,
  input  logic [7:0] flag_a_set,
  input  logic [3:0] flag_b_set,
  output logic [7:0] rd_data,
  output logic       bit_val,
  output logic       err
);
  logic [NREG-1:0]      hit;
  logic                 do_write, do_test, do_read, bad;
  logic [DW-1:0]        wmask, wval, sel;
  logic [DW-1:0]        hw_v [NREG];
  logic [DW-1:0]        q_arr [NREG];
  logic [NREG*DW-1:0]   q_flat;

  iosp_decode u_dec (
    .req_en, .req_kind, .req_wr, .req_addr, .wr_data, .bit_sel,
    .hit, .do_write, .do_test, .do_read, .wmask, .wval, .bad
  );

  always_comb begin
    for (int i = 0; i < NREG; i++) hw_v[i] = '0;
    hw_v[IDX_FLAGA] = flag_a_set;
    hw_v[IDX_FLAGB] = {4'b0, flag_b_set};
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    iosp_cell #(.MASK(reg_mask(i)), .W1C(reg_w1c(i))) u_cell (
      .clk, .rst,
      .we(do_write && hit[i]),
      .wmask, .wval,
      .hw_set(hw_v[i]),
      .q(q_arr[i])
    );
    assign q_flat[i*DW +: DW] = q_arr[i];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) sel = sel | q_arr[i];
  end

  assign rd_data = do_read ? sel : '0;
  assign bit_val = do_test && sel[bit_sel];

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= bad;
  end
endmodule

// File: rtl/iospace_regfile_chk.sv
module iospace_regfile_chk
  import iosp_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               req_en,
  input logic [2:0]         req_kind,
  input logic [9:0]         req_addr,
  input logic [7:0]         flag_a_set,
  input logic               bit_val,
  input logic               err,
  input logic [NREG*DW-1:0] q_flat
);
  logic [DW-1:0] q_fa, q_ctl, q_eb;
  assign q_fa  = q_flat[IDX_FLAGA*DW +: DW];
  assign q_ctl = q_flat[IDX_CTRLA*DW +: DW];
  assign q_eb  = q_flat[IDX_EXTB*DW +: DW];

  p_port_range_r1: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_kind == 3'd0 && req_addr >= 10'h040) |=> err);

  p_data_range_r2: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_kind == 3'd1 && (req_addr < 10'h020 || req_addr > 10'h1FF)) |=> err);

  p_bit_range_r4: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_kind >= 3'd2 && req_kind <= 3'd4 && req_addr >= 10'h020) |=> err);

  p_test_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_kind == 3'd4 && req_addr >= 10'h020) |-> !bit_val);

  p_hw_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_a_set != 8'h00) |=> ((q_fa & $past(flag_a_set)) == $past(flag_a_set)));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (q_ctl[7:6] == 2'b00) && (q_eb[7:4] == 4'h0));

  p_err_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !req_en |=> !err);

  p_bad_kind_r12: assert property (@(posedge clk) disable iff (rst)
    (req_en && req_kind > 3'd4) |=> err);
endmodule

bind iospace_regfile iospace_regfile_chk u_chk (
  .clk(clk), .rst(rst), .req_en(req_en), .req_kind(req_kind),
  .req_addr(req_addr), .flag_a_set(flag_a_set), .bit_val(bit_val),
  .err(err), .q_flat(q_flat)
);

// File: tb/iospace_regfile_bench.sv
module iospace_regfile_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_en = 1'b0;
  logic [2:0] req_kind = '0;
  logic       req_wr = 1'b0;
  logic [9:0] req_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] flag_a_set = '0;
  logic [3:0] flag_b_set = '0;
  logic [7:0] rd_data;
  logic       bit_val;
  logic       err;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] m [8];

  always #(CLK_P/2) clk = ~clk;

  iospace_regfile u_iospace_regfile (.*);

  function automatic int ridx(input int da);
    case (da)
      'h022: return 0;  'h025: return 1;  'h02C: return 2;  'h03A: return 3;
      'h04A: return 4;  'h05E: return 5;  'h0A0: return 6;  'h1FF: return 7;
      default: return -1;
    endcase
  endfunction
  function automatic logic [7:0] rmask(input int i);
    return (i == 2) ? 8'h3F : (i == 7) ? 8'h0F : 8'hFF;
  endfunction
  function automatic logic [7:0] rw1c(input int i);
    return (i == 1) ? 8'hFF : (i == 3) ? 8'h0F : 8'h00;
  endfunction

  // model write per R5/R6/R9: plain bits take value, flags clear on one
  task automatic mwrite(input int i, input logic [7:0] wm, input logic [7:0] wv);
    logic [7:0] pl;
    if (i < 0) return;
    pl = rmask(i) & ~rw1c(i);
    m[i] = (((m[i] & ~wm) | (wv & wm)) & pl) | (m[i] & ~(wm & wv) & rw1c(i));
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic op(input int k, input logic w, input int a, input logic [7:0] d,
                    input int b, output logic [7:0] rd, output logic bv, output logic e);
    @(negedge clk);
    req_en = 1'b1; req_kind = k[2:0]; req_wr = w; req_addr = a[9:0];
    wr_data = d; bit_sel = b[2:0];
    #1; rd = rd_data; bv = bit_val;
    @(posedge clk); #1;
    e = err;
    req_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd; logic bv, e;
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R11 err after reset", err, 0);

    // reset contents, port reads
    for (int a = 0; a < 64; a++) begin
      op(0, 0, a, 0, 0, rd, bv, e);
      check("R11 reset read", rd, 0);
      check("R10 read no err", e, 0);
    end

    // port write sweep, data read back
    for (int a = 0; a < 64; a++) begin
      logic [7:0] d;
      int i;
      d = 8'((a * 37 + 11) & 255);
      i = ridx(a + 32);
      op(0, 1, a, d, 0, rd, bv, e);
      check("R10 port write err", e, i < 0);
      mwrite(i, 8'hFF, d);
      op(1, 0, a + 32, 0, 0, rd, bv, e);
      check("R2 data alias read", rd, (i < 0) ? 0 : m[i]);
    end
    check("R8 GP0 holds", m[0], 8'((2 * 37 + 11) & 255));
    for (int a = 64; a < 256; a += 16) begin
      op(0, 0, a, 0, 0, rd, bv, e);
      check("R1 port range rd", rd, 0);
      check("R1 port range err", e, 1);
    end
    op(0, 1, 'hA0 - 32, 8'h77, 0, rd, bv, e);
    check("R3 ext not via port err", e, 1);

    // data sweep over the full address bus
    for (int a = 0; a < 1024; a++) begin
      logic [7:0] d;
      int i;
      bit legal;
      d = 8'((a * 13 + 90) & 255);
      legal = (a >= 'h20) && (a <= 'h1FF);
      i = legal ? ridx(a) : -1;
      op(1, 1, a, d, 0, rd, bv, e);
      check("R2 data write err", e, !legal || i < 0);
      mwrite(i, 8'hFF, d);
      op(1, 0, a, 0, 0, rd, bv, e);
      check("R3 data read", rd, (i < 0) ? 0 : m[i]);
      check("R2 data read err", e, !legal);
    end
    check("R9 CTRLA reserved", m[2] & 8'hC0, 0);

    // bit operation sweep
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 8; b++) begin
        int i;
        bit inwin;
        inwin = a < 32;
        i = inwin ? ridx(a + 32) : -1;
        op(2, 0, a, 0, b, rd, bv, e);
        check("R4 bset err", e, !inwin || i < 0);
        mwrite(i, 8'h01 << b, 8'hFF);
        op(4, 0, a, 0, b, rd, bv, e);
        check("R5 btest after set", bv, (i < 0) ? 0 : m[i][b]);
        check("R4 btest err", e, !inwin);
        op(3, 0, a, 0, b, rd, bv, e);
        check("R4 bclr err", e, !inwin || i < 0);
        mwrite(i, 8'h01 << b, 8'h00);
        op(4, 0, a, 0, b, rd, bv, e);
        check("R5 btest after clr", bv, (i < 0) ? 0 : m[i][b]);
      end
    end

    // FLAGB: bit op versus full write
    op(0, 1, 'h1A, 8'h00, 0, rd, bv, e);
    flag_b_set = 4'hF; idle(); flag_b_set = 4'h0;
    op(0, 0, 'h1A, 0, 0, rd, bv, e);
    check("R7 hw set flags", rd, 8'h0F);
    op(2, 0, 'h1A, 0, 6, rd, bv, e);
    op(0, 0, 'h1A, 0, 0, rd, bv, e);
    check("R5 bset keeps flags", rd, 8'h4F);
    op(3, 0, 'h1A, 0, 1, rd, bv, e);
    op(0, 0, 'h1A, 0, 0, rd, bv, e);
    check("R6 bclr on flag no effect", rd, 8'h4F);
    op(0, 1, 'h1A, 8'h05, 0, rd, bv, e);
    op(0, 0, 'h1A, 0, 0, rd, bv, e);
    check("R6 full write clears ones", rd, 8'h0A);
    op(2, 0, 'h1A, 0, 3, rd, bv, e);
    op(0, 0, 'h1A, 0, 0, rd, bv, e);
    check("R6 bset clears flag", rd, 8'h02);

    // FLAGA: set versus clear in one cycle
    flag_a_set = 8'hFF; idle(); flag_a_set = 8'h81;
    op(0, 1, 'h05, 8'hFF, 0, rd, bv, e);
    flag_a_set = 8'h00;
    op(1, 0, 'h25, 0, 0, rd, bv, e);
    check("R7 set wins over clear", rd, 8'h81);

    // illegal kinds
    op(0, 1, 'h02, 8'h3C, 0, rd, bv, e);
    for (int k = 5; k < 8; k++) begin
      op(k, 1, 'h02, 8'hC3, 0, rd, bv, e);
      check("R12 bad kind err", e, 1);
    end
    op(0, 0, 'h02, 0, 0, rd, bv, e);
    check("R12 bad kind no change", rd, 8'h3C);
    check("R8 GP0 value", rd, 8'h3C);

    // synchronous reset
    @(negedge clk); rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
    for (int a = 0; a < 64; a++) begin
      op(0, 0, a, 0, 0, rd, bv, e);
      check("R11 cleared by reset", rd, 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule